// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and takes the device from power-up to ready. While the supplies and clock are not yet stable, the clock enable stays low and only NOP is driven. Once `stable_i` is seen high, the block waits a fixed power-up delay. The length of that delay comes from a clock-frequency parameter, and a simulation override can shorten it. The block then raises the clock enable and issues a fixed series of commands. These are a precharge of all banks, an extended-mode load that enables the DLL, a mode load that resets the DLL, a second precharge of all banks, and two auto refreshes. The last command is a mode load that clears the DLL-reset bit and keeps the operating fields.

Every command lasts one cycle. NOP fills each cycle between commands. The spacing after a precharge, a mode load and a refresh is set by parameters. The done flag rises only when the last mode load has had its settle time and the DLL lock window has also run out. That window is counted from the DLL-reset load. Pulling the reset low at any point starts the sequence again, with the clock enable low.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_ni` is low, `cke_o` is 0, `done_o` is 0 and the command pins {cs,ras,cas,we} read NOP (4'b0111). Releasing reset restarts the whole sequence from the stable wait.
- R2: `cke_o` stays 0 for as long as `stable_i` has not been sampled high, and for the whole power-up delay. While `cke_o` is 0, no command other than NOP is driven. Once `cke_o` is 1 it does not fall until reset.
- R3: The first cycle with `cke_o` high drives NOP. It comes exactly PWRUP+1 cycles after the clock edge that first samples `stable_i` high. PWRUP is SIM_PWRUP_CYC when that parameter is nonzero, and CLK_MHZ*PWRUP_US otherwise.
- R4: Command encodings on {cs,ras,cas,we} are NOP 0111, precharge 0010, mode load 0000 and auto refresh 0001. A precharge drives address 13'h0400, so A10 is set to select all banks. NOP and refresh drive address 0 and bank 0.
- R5: After the opening NOP the order is: precharge-all, extended-mode load, DLL-reset mode load, precharge-all, refresh, refresh, final mode load. No other command follows.
- R6: The extended-mode load drives bank 2'b01 and address EMR_VAL.
- R7: The DLL-reset mode load drives bank 2'b00 and address MR_VAL with bit 8 set. The final mode load drives bank 2'b00 and address MR_VAL with bit 8 cleared, with every other bit kept.
- R8: Spacing between commands: NOP to the first precharge is 1 cycle. A precharge is followed by the next command T_RP cycles later. A mode load is followed by the next command T_MRD cycles later. A refresh is followed by the next command T_RFC cycles later. Each spacing parameter is at least 2.
- R9: `done_o` rises in cycle max(f+T_MRD, d+DLL_CYC)+1. Here f is the cycle of the final mode load and d is the cycle of the DLL-reset load. Once high, `done_o` stays high with `cke_o` high until reset.
- R10: While `done_o` is high, only NOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, restarts the sequence |
| stable_i | input | 1 | Supplies and clock are stable |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| done_o | output | 1 | Initialization complete |

## Verification
The assertions check the cycle-local rules on every cycle. While the clock enable is low, only NOP appears. Precharge always carries A10. Mode loads target only the base or the extended register. The clock enable and the done flag never fall outside reset, and only NOP is driven after done. Other behaviours can only be shown by the bench's scenarios. These are the command order, the exact spacing between commands, the address values for each mode load, and the cycle in which done rises relative to the DLL-reset load. The bench also shows that a reset in the middle of the sequence starts it again from the power-up delay.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int unsigned ADDR_W      = 13;
  localparam int unsigned BA_W        = 2;
  localparam int unsigned DLL_RST_BIT = 8;
  localparam int unsigned AP_BIT      = 10;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_LMR, CMD_REF} cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_NOP, S_PRE1, S_EMR, S_MR_RST, S_PRE2,
    S_REF1, S_REF2, S_MR_RUN, S_GAP, S_HOLD, S_DONE
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/ddr_init_dll_win.sv
module ddr_init_dll_win #(
  parameter int unsigned DLL_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(DLL_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CW'(DLL_CYC - 1);
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
(
  input  cmd_e  cmd_i,
  output pins_t pins_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_PRE: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_LMR: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_REF: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default: pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned       CLK_MHZ       = 200,
  parameter int unsigned       PWRUP_US      = 200,
  parameter int unsigned       SIM_PWRUP_CYC = 0,
  parameter int unsigned       T_RP          = 3,
  parameter int unsigned       T_MRD         = 2,
  parameter int unsigned       T_RFC         = 14,
  parameter int unsigned       DLL_CYC       = 200,
  parameter logic [ADDR_W-1:0] MR_VAL        = 13'h0032,
  parameter logic [ADDR_W-1:0] EMR_VAL       = 13'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stable_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int unsigned PWRUP_CYC = (SIM_PWRUP_CYC != 0) ? SIM_PWRUP_CYC : CLK_MHZ * PWRUP_US;
  localparam int unsigned RP_GAP    = (T_RP  < 2) ? 2 : T_RP;
  localparam int unsigned MRD_GAP   = (T_MRD < 2) ? 2 : T_MRD;
  localparam int unsigned RFC_GAP   = (T_RFC < 2) ? 2 : T_RFC;
  localparam int unsigned MAX_GAP   = (RFC_GAP > RP_GAP) ?
                                      ((RFC_GAP > MRD_GAP) ? RFC_GAP : MRD_GAP) :
                                      ((RP_GAP  > MRD_GAP) ? RP_GAP  : MRD_GAP);
  localparam int unsigned MAX_CNT   = (PWRUP_CYC > MAX_GAP) ? PWRUP_CYC : MAX_GAP;
  localparam int unsigned TW        = $clog2(MAX_CNT + 1);
  localparam logic [ADDR_W-1:0] DLL_MASK   = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] AP_MASK    = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MR_RST_VAL = MR_VAL | DLL_MASK;
  localparam logic [ADDR_W-1:0] MR_RUN_VAL = MR_VAL & ~DLL_MASK;

  state_e            state_q, state_d, nxt_q, nxt_d;
  logic              cke_q;
  logic              ld;
  logic [TW-1:0]     ld_val;
  logic              gap_last;
  logic              dll_start, dll_expired;
  cmd_e              cmd;
  pins_t             pins;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  ddr_init_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .last_o (gap_last)
  );

  ddr_init_dll_win #(.DLL_CYC(DLL_CYC)) u_dll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dll_start),
    .expired_o (dll_expired)
  );

  ddr_init_cmd_enc u_enc (
    .cmd_i  (cmd),
    .pins_o (pins)
  );

  always_comb begin
    state_d   = state_q;
    nxt_d     = nxt_q;
    ld        = 1'b0;
    ld_val    = '0;
    cmd       = CMD_NOP;
    ba        = '0;
    addr      = '0;
    dll_start = 1'b0;
    unique case (state_q)
      S_IDLE: if (stable_i) begin
        state_d = S_GAP; nxt_d = S_NOP; ld = 1'b1; ld_val = TW'(PWRUP_CYC);
      end
      S_NOP: state_d = S_PRE1;
      S_PRE1: begin
        cmd = CMD_PRE; addr = AP_MASK;
        state_d = S_GAP; nxt_d = S_EMR; ld = 1'b1; ld_val = TW'(RP_GAP - 1);
      end
      S_EMR: begin
        cmd = CMD_LMR; ba = 2'b01; addr = EMR_VAL;
        state_d = S_GAP; nxt_d = S_MR_RST; ld = 1'b1; ld_val = TW'(MRD_GAP - 1);
      end
      S_MR_RST: begin
        cmd = CMD_LMR; addr = MR_RST_VAL; dll_start = 1'b1;
        state_d = S_GAP; nxt_d = S_PRE2; ld = 1'b1; ld_val = TW'(MRD_GAP - 1);
      end
      S_PRE2: begin
        cmd = CMD_PRE; addr = AP_MASK;
        state_d = S_GAP; nxt_d = S_REF1; ld = 1'b1; ld_val = TW'(RP_GAP - 1);
      end
      S_REF1: begin
        cmd = CMD_REF;
        state_d = S_GAP; nxt_d = S_REF2; ld = 1'b1; ld_val = TW'(RFC_GAP - 1);
      end
      S_REF2: begin
        cmd = CMD_REF;
        state_d = S_GAP; nxt_d = S_MR_RUN; ld = 1'b1; ld_val = TW'(RFC_GAP - 1);
      end
      S_MR_RUN: begin
        cmd = CMD_LMR; addr = MR_RUN_VAL;
        state_d = S_GAP; nxt_d = S_HOLD; ld = 1'b1; ld_val = TW'(MRD_GAP - 1);
      end
      S_GAP:  if (gap_last) state_d = nxt_q;
      S_HOLD: if (dll_expired) state_d = S_DONE;
      S_DONE: state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      nxt_q   <= S_IDLE;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      if (state_d == S_NOP) cke_q <= 1'b1;
    end
  end

  assign cke_o   = cke_q;
  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;
  assign ba_o    = ba;
  assign addr_o  = addr;
  assign done_o  = (state_q == S_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cke_o,
  input logic        cs_n_o,
  input logic        ras_n_o,
  input logic        cas_n_o,
  input logic        we_n_o,
  input logic [1:0]  ba_o,
  input logic [12:0] addr_o,
  input logic        done_o
);
  logic [3:0] pins;
  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  // R2
  cke_low_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> pins == 4'b0111);

  // R2
  cke_no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R4
  pre_all_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins == 4'b0010 |-> addr_o[10]);

  // R6
  lmr_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins == 4'b0000 |-> ba_o[1] == 1'b0);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R9
  done_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cke_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pins == 4'b0111);
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cke_o   (cke_o),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .done_o  (done_o)
);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP  = 40;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_RFC  = 10;
  localparam int DLL    = 200;
  localparam logic [12:0] MR  = 13'h0032;
  localparam logic [12:0] EMR = 13'h0002;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stable_i = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(100), .PWRUP_US(200), .SIM_PWRUP_CYC(PWRUP),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_CYC(DLL),
    .MR_VAL(MR), .EMR_VAL(EMR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stable_i(stable_i), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .done_o(done_o)
  );

  typedef struct {
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [12:0] addr;
    int          gap;
    int          kind;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int last_cyc = 0, d_cyc = 0, f_cyc = 0, done_exp = 0, ev_cnt = 0, post_done_ev = 0;
  bit done_armed = 0, viol = 0, cke_prev = 0, done_prev = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [3:0] p, input logic [1:0] b, input logic [12:0] a,
                      input int g, input int k, input string t);
    exp_t e;
    e.pins = p; e.ba = b; e.addr = a; e.gap = g; e.kind = k; e.tag = t;
    q.push_back(e);
  endtask

  task automatic push_run();
    push(4'b0111, 2'b00, 13'h0000, PWRUP + 1, 0, "R3 first NOP with cke");
    push(4'b0010, 2'b00, 13'h0400, 1,         0, "R5 precharge-all 1");
    push(4'b0000, 2'b01, EMR,      T_RP,      0, "R6 extended mode load");
    push(4'b0000, 2'b00, MR | 13'h0100, T_MRD, 1, "R7 DLL-reset mode load");
    push(4'b0010, 2'b00, 13'h0400, T_MRD,     0, "R8 precharge-all 2");
    push(4'b0001, 2'b00, 13'h0000, T_RP,      0, "R4 refresh 1");
    push(4'b0001, 2'b00, 13'h0000, T_RFC,     0, "R8 refresh 2");
    push(4'b0000, 2'b00, MR & ~13'h0100, T_RFC, 2, "R7 final mode load");
  endtask

  // monitor
  always @(negedge clk) begin
    logic [3:0] p;
    bit ev;
    p = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    if (!rst_ni) begin
      cke_prev  = 0;
      done_prev = 0;
    end else begin
      if (!cke_o && p != 4'b0111) viol = 1;
      ev = (cke_o && !cke_prev) || (cke_o && p != 4'b0111);
      if (ev) begin
        ev_cnt++;
        if (done_o) post_done_ev++;
        if (q.size() == 0) begin
          chk(0, "R5 unexpected command", int'(p), 7);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(p == e.pins, {e.tag, " pins"}, int'(p), int'(e.pins));
          chk(ba_o == e.ba && addr_o == e.addr, {e.tag, " ba/addr"},
              int'({ba_o, addr_o}), int'({e.ba, e.addr}));
          chk(cyc - last_cyc == e.gap, {e.tag, " spacing"}, cyc - last_cyc, e.gap);
          if (e.kind == 1) d_cyc = cyc;
          if (e.kind == 2) begin
            f_cyc = cyc;
            done_exp = ((f_cyc + T_MRD > d_cyc + DLL) ? f_cyc + T_MRD : d_cyc + DLL) + 1;
            done_armed = 1;
          end
        end
        last_cyc = cyc;
      end
      if (done_o && !done_prev)
        chk(done_armed && cyc == done_exp, "R9 done rise cycle", cyc, done_exp);
      cke_prev  = cke_o;
      done_prev = done_o;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done();
    while (!done_o) tick(1);
  endtask

  task automatic finish_run(input string name);
    tick(30);
    chk(q.size() == 0, {"R5 all commands seen ", name}, q.size(), 0);
    chk(post_done_ev == 0, {"R10 NOP after done ", name}, post_done_ev, 0);
    chk(!viol, {"R2 no command with cke low ", name}, int'(viol), 0);
    chk(done_o && cke_o, {"R9 done held ", name}, int'({done_o, cke_o}), 3);
  endtask

  task automatic check_reset_state(input string name);
    chk(!cke_o && !done_o, {"R1 cke/done in reset ", name}, int'({cke_o, done_o}), 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, {"R1 NOP in reset ", name},
        int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 7);
  endtask

  initial begin
    tick(3);
    check_reset_state("initial");
    rst_ni = 1'b1;
    tick(12);
    chk(!cke_o, "R2 cke low while not stable", int'(cke_o), 0);
    // run 1
    push_run();
    last_cyc = cyc;
    stable_i = 1'b1;
    tick(PWRUP / 2);
    chk(!cke_o, "R2 cke low during power-up delay", int'(cke_o), 0);
    wait_done();
    finish_run("run1");
    // run 2: reset mid-sequence
    rst_ni = 1'b0;
    tick(1);
    check_reset_state("after done");
    q.delete(); done_armed = 0; post_done_ev = 0;
    push_run();
    last_cyc = cyc;
    ev_cnt = 0;
    rst_ni = 1'b1;
    while (ev_cnt < 3) tick(1);
    rst_ni = 1'b0;
    #1;
    check_reset_state("mid-sequence");
    tick(2);
    q.delete(); done_armed = 0;
    // run 3: full restart
    push_run();
    last_cyc = cyc;
    rst_ni = 1'b1;
    wait_done();
    finish_run("run3");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule